// File: doc/BRIEF.md
# Lane Inversion Sweep Pointer Generator

This block produces the per-lane receive inversion mask for a serial link self-test that spans a 14-lane port. A pattern ring holds one bit per lane position. A set bit means the data expected on that lane is inverted. Software-style configuration strobes set the sweep mode, the reference-group select and the automatic sweep enable. A separate seed strobe loads the ring.

When automatic sweep is on, each step strobe advances the pattern by one position. In full mode the ring is one rotation through all 14 positions. The top position has no physical receiver, but it still carries a bit through the ring. In grouped mode, each complete five-lane group rotates within itself. The mask then copies one five-lane reference group, picked by the select bit, onto every group of the port. The four-lane top group takes the lower four reference bits.

The mask is a combinational view of the ring and the configuration registers. A change therefore reaches the mask in the cycle after its strobe edge.

Top module: `lane_inv_sweep`

## Requirements
- R1: After reset, the mask reads all zeros, grouped mode is selected, reference group 0 is selected and automatic sweep is off.
- R2: A seed strobe copies `seed_val` into the ring, and the ring is visible on `inv_mask` in full mode from the next cycle.
- R3: A seed strobe wins over a step strobe in the same cycle: the ring takes the seed unrotated.
- R4: In full mode with automatic sweep on, each step moves the bit of lane i to lane i+1, and lane 13 wraps to lane 0.
- R5: In grouped mode with select 0, `inv_mask[i]` equals ring bit (i mod 5) for every lane.
- R6: In grouped mode with select 1, `inv_mask[i]` equals ring bit 5 + (i mod 5) for every lane.
- R7: In grouped mode, each step rotates ring lanes 4:0 and 9:5 left within their own group (bit 4 to bit 0, bit 9 to bit 5), so five steps restore the pattern. Ring lanes 13:10 hold their value.
- R8: With automatic sweep off, step strobes have no effect on the mask.
- R9: With automatic sweep on, the ring holds in any cycle without a step strobe.
- R10: Mode, select and enable change only in a cycle with `cfg_we` high. Otherwise `cfg_full`, `cfg_map` and `cfg_auto` are ignored.
- R11: In grouped mode, mask lanes 13:10 equal reference bits 3:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_full | input | 1 | 1 selects full mode, 0 selects grouped mode |
| cfg_map | input | 1 | Reference group select: 0 picks lanes 4:0, 1 picks lanes 9:5 |
| cfg_auto | input | 1 | Automatic sweep enable |
| seed_we | input | 1 | Seed load strobe |
| seed_val | input | 14 | Seed pattern, one bit per lane |
| step | input | 1 | Sweep step strobe |
| inv_mask | output | 14 | Per-lane inversion mask |

## Verification
A wrong ring bit shows on the mask in the cycle after the edge that stored it. In full mode it shows at its own lane. In grouped mode it shows on every lane that copies it, or it stays hidden until a mode or select change exposes it. A misrouted rotation shows after one step as a bit at the wrong lane. A wrong configuration bit changes the whole mask from the next cycle. The bench follows a behavioural model every cycle, moves through all mode and select combinations, and reads the ring in full mode after grouped sweeps, so that hidden ring state is brought to the ports.

// File: rtl/lis_pkg.sv
package lis_pkg;

   typedef struct packed {
      logic full;
      logic map;
      logic auto_en;
   } sweep_cfg_t;

   localparam sweep_cfg_t CFG_RESET = '{full: 1'b0, map: 1'b0, auto_en: 1'b0};

   // source lane for a left rotation by one inside a ring of span n at base b
   function automatic int rot_src(input int lane, input int base, input int span);
      return base + (((lane - base) + span - 1) % span);
   endfunction

endpackage

// File: rtl/lis_ctrl.sv
module lis_ctrl
   import lis_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       we,
   input  sweep_cfg_t wr_cfg,
   output sweep_cfg_t cfg
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  cfg <= CFG_RESET;
      else if (we) cfg <= wr_cfg;
   end

   p_cfg_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(cfg));

   p_cfg_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> cfg == $past(wr_cfg));

endmodule

// File: rtl/lis_ring.sv
module lis_ring
   import lis_pkg::*;
#(
   parameter int              LANES    = 14,
   parameter int              GRP      = 5,
   parameter logic [LANES-1:0] RST_PAT = '0
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [LANES-1:0] seed,
   input  logic             adv,
   input  logic             full,
   output logic [LANES-1:0] pat
);

   localparam int NFULL  = LANES / GRP;
   localparam int COVER  = NFULL * GRP;
   localparam bit HAS_TAIL = (COVER < LANES);

   logic [LANES-1:0] nxt_full;
   logic [LANES-1:0] nxt_grp;
   logic [LANES-1:0] nxt;

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      localparam int G    = i / GRP;
      localparam int SRCF = rot_src(i, 0, LANES);
      assign nxt_full[i] = pat[SRCF];
      if (G < NFULL) begin : g_in
         localparam int SRCG = rot_src(i, G * GRP, GRP);
         assign nxt_grp[i] = pat[SRCG];
      end else begin : g_tail
         assign nxt_grp[i] = pat[i];
      end
   end

   always_comb begin
      if (load)     nxt = seed;
      else if (adv) nxt = full ? nxt_full : nxt_grp;
      else          nxt = pat;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pat <= RST_PAT;
      else        pat <= nxt;
   end

   p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> pat == $past(seed));

   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !adv) |=> $stable(pat));

   p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && full && !load) |=> pat[0] == $past(pat[LANES-1]));

   p_ones_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $countones(pat) == $countones($past(pat)));

   p_gwrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !full && !load) |=> pat[0] == $past(pat[GRP-1]));

   if (HAS_TAIL) begin : g_tail_chk
      p_tail_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (adv && !full && !load) |=> pat[LANES-1:COVER] == $past(pat[LANES-1:COVER]));
   end

endmodule

// File: rtl/lis_mask.sv
module lis_mask
   import lis_pkg::*;
#(
   parameter int LANES = 14,
   parameter int GRP   = 5
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LANES-1:0] pat,
   input  logic             full,
   input  logic             map,
   output logic [LANES-1:0] mask
);

   logic [GRP-1:0] ref_grp;

   assign ref_grp = map ? pat[2*GRP-1:GRP] : pat[GRP-1:0];

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      localparam int RB = i % GRP;
      assign mask[i] = full ? pat[i] : ref_grp[RB];
      if (i >= GRP) begin : g_rep
         p_rep_r5: assert property (@(posedge clk) disable iff (!rst_n)
            !full |-> mask[i] == mask[RB]);
      end
   end

   p_sel_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!full && map) |-> mask[GRP-1:0] == pat[2*GRP-1:GRP]);

   p_top_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !full |-> mask[LANES-1] == mask[(LANES-1) % GRP]);

endmodule

// File: rtl/lane_inv_sweep.sv
module lane_inv_sweep
   import lis_pkg::*;
#(
   parameter int LANES = 14,
   parameter int GRP   = 5
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic             cfg_full,
   input  logic             cfg_map,
   input  logic             cfg_auto,
   input  logic             seed_we,
   input  logic [LANES-1:0] seed_val,
   input  logic             step,
   output logic [LANES-1:0] inv_mask
);

   if (GRP < 2) begin : g_bad_grp
      $error("lane_inv_sweep: GRP must be at least 2");
   end
   if (LANES < 2 * GRP) begin : g_bad_lanes
      $error("lane_inv_sweep: LANES must hold two full groups");
   end

   sweep_cfg_t       wr_cfg;
   sweep_cfg_t       cfg;
   logic [LANES-1:0] pat;
   logic             adv;

   assign wr_cfg = '{full: cfg_full, map: cfg_map, auto_en: cfg_auto};
   assign adv    = cfg.auto_en & step;

   lis_ctrl u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (cfg_we),
      .wr_cfg (wr_cfg),
      .cfg    (cfg)
   );

   lis_ring #(.LANES(LANES), .GRP(GRP)) u_ring (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (seed_we),
      .seed  (seed_val),
      .adv   (adv),
      .full  (cfg.full),
      .pat   (pat)
   );

   lis_mask #(.LANES(LANES), .GRP(GRP)) u_mask (
      .clk   (clk),
      .rst_n (rst_n),
      .pat   (pat),
      .full  (cfg.full),
      .map   (cfg.map),
      .mask  (inv_mask)
   );

   p_noauto_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg.auto_en && !seed_we && !cfg_we) |=> $stable(inv_mask));

   p_prio_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (seed_we && step) |=> pat == $past(seed_val));

endmodule

// File: tb/sim_lane_inv_sweep.sv
module sim_lane_inv_sweep;

   localparam int L = 14;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cfg_we = 1'b0, cfg_full = 1'b0, cfg_map = 1'b0, cfg_auto = 1'b0;
   logic         seed_we = 1'b0, step = 1'b0;
   logic [L-1:0] seed_val = '0;
   logic [L-1:0] inv_mask;

   int    n_tests = 0;
   int    n_fail  = 0;
   bit    done    = 1'b0;
   string cur_req = "R1";

   logic [L-1:0] m_pat = '0;
   bit           m_full = 0, m_map = 0, m_auto = 0;

   always #2 clk = ~clk;

   lane_inv_sweep u0 (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_full(cfg_full),
      .cfg_map(cfg_map), .cfg_auto(cfg_auto), .seed_we(seed_we),
      .seed_val(seed_val), .step(step), .inv_mask(inv_mask)
   );

   function automatic logic [L-1:0] model_mask();
      logic [L-1:0] r;
      for (int i = 0; i < L; i++) begin
         if (m_full)     r[i] = m_pat[i];
         else if (m_map) r[i] = m_pat[5 + (i % 5)];
         else            r[i] = m_pat[i % 5];
      end
      return r;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_pat = '0; m_full = 0; m_map = 0; m_auto = 0;
      end else begin
         logic [L-1:0] nx;
         nx = m_pat;
         if (seed_we) nx = seed_val;
         else if (m_auto && step) begin
            if (m_full) begin
               for (int i = 0; i < L; i++) nx[(i + 1) % L] = m_pat[i];
            end else begin
               for (int i = 0; i < 10; i++) nx[(i / 5) * 5 + ((i % 5) + 1) % 5] = m_pat[i];
            end
         end
         m_pat = nx;
         if (cfg_we) begin
            m_full = cfg_full; m_map = cfg_map; m_auto = cfg_auto;
         end
      end
   end

   task automatic check();
      logic [L-1:0] exp;
      exp = model_mask();
      n_tests++;
      if (inv_mask !== exp) begin
         n_fail++;
         $display("FAIL %s: inv_mask=%b expected=%b", cur_req, inv_mask, exp);
      end
   endtask

   task automatic cyc(input bit ld, input logic [L-1:0] sd, input bit st);
      seed_we = ld; seed_val = sd; step = st;
      @(negedge clk);
      seed_we = 1'b0; step = 1'b0; cfg_we = 1'b0;
      check();
   endtask

   task automatic cfg(input bit f, input bit m, input bit a);
      cfg_we = 1'b1; cfg_full = f; cfg_map = m; cfg_auto = a;
      cyc(1'b0, '0, 1'b0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      cur_req = "R1";
      check();
      if (inv_mask !== '0) begin
         n_fail++;
         $display("FAIL R1: reset mask=%b expected=0", inv_mask);
      end
      n_tests++;

      cur_req = "R8";
      cyc(1'b1, 14'b00_0001_0010_0011, 1'b0);
      for (int k = 0; k < 4; k++) cyc(1'b0, '0, 1'b1);
      cfg(1'b1, 1'b0, 1'b0);
      cyc(1'b0, '0, 1'b1);

      cur_req = "R2";
      cyc(1'b1, 14'b10_1100_0101_1001, 1'b0);
      cyc(1'b1, 14'b01_0000_0000_0001, 1'b0);

      cur_req = "R4";
      cfg(1'b1, 1'b0, 1'b1);
      cyc(1'b1, 14'b10_0000_0000_0000, 1'b0);
      for (int k = 0; k < 16; k++) cyc(1'b0, '0, 1'b1);
      cyc(1'b1, 14'b11_0010_1000_0110, 1'b0);
      for (int k = 0; k < 15; k++) cyc(1'b0, '0, 1'b1);

      cur_req = "R9";
      for (int k = 0; k < 3; k++) cyc(1'b0, '0, 1'b0);

      cur_req = "R3";
      cyc(1'b1, 14'b00_0000_0011_1111, 1'b1);
      cyc(1'b0, '0, 1'b1);

      cur_req = "R5";
      cfg(1'b0, 1'b0, 1'b1);
      cyc(1'b1, 14'b11_1000_1100_1101, 1'b0);
      cur_req = "R7";
      for (int k = 0; k < 10; k++) cyc(1'b0, '0, 1'b1);
      cur_req = "R11";
      cyc(1'b1, 14'b00_0000_0000_1110, 1'b0);
      cyc(1'b0, '0, 1'b1);

      cur_req = "R6";
      cfg(1'b0, 1'b1, 1'b1);
      cyc(1'b1, 14'b01_0110_1000_0001, 1'b0);
      for (int k = 0; k < 6; k++) cyc(1'b0, '0, 1'b1);

      cur_req = "R7";
      cfg(1'b1, 1'b1, 1'b0);
      cyc(1'b0, '0, 1'b0);

      cur_req = "R10";
      cfg_full = 1'b0; cfg_map = 1'b0; cfg_auto = 1'b1;
      cyc(1'b0, '0, 1'b1);
      cyc(1'b0, '0, 1'b1);

      cur_req = "R4";
      cfg(1'b1, 1'b0, 1'b1);
      for (int k = 0; k < 60; k++) begin
         cfg_we   = ($urandom % 8) == 0;
         cfg_full = $urandom; cfg_map = $urandom; cfg_auto = $urandom;
         cyc(($urandom % 5) == 0, L'($urandom), $urandom);
      end

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #800000;
      if (!done) begin
         n_fail++;
         n_tests++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule